// File: doc/BRIEF.md
# Line Pixel Walker

This block traces a straight line between two points on a 16-bit integer grid. It produces one pixel coordinate per clock until it reaches the far endpoint. A single-cycle `start` pulse captures both endpoints. Setup derives the absolute horizontal span, the negative vertical span and the two step directions in that same cycle. The walker then advances an integer error term. It can move one unit in x, in y, or in both during a cycle, so a line of horizontal span `a` and vertical span `b` takes exactly `max(a, b) + 1` cycles of `pix_valid`.

The vertical span is kept zero or negative. Both step tests compare the same doubled error value, one against that negative span and one against the positive horizontal span. This is what allows a diagonal move to finish in a single cycle. Once the endpoint has been emitted, the block parks in a finished state with `done` high. It waits there until the next `start` pulse, which launches a fresh line straight away.

Top module: `line_walker`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `pix_valid` and `done` are both 0.
- R2: A `start` pulse seen while idle or finished captures `x0`, `y0`, `x1` and `y1`. In the following cycle `pix_valid` is 1 and (`pix_x`, `pix_y`) equals (`x0`, `y0`). Later changes on the four coordinate inputs do not affect the line in progress.
- R3: Every cycle with `pix_valid` high carries one pixel. Two consecutive pixels differ by at most one unit on each axis and are never identical.
- R4: x only ever moves toward `x1`: it increments when `x1 > x0` and decrements otherwise. y only ever moves toward `y1` under the same rule.
- R5: The error term starts at `sx + sy`, where `sx = |x1 - x0|` and `sy = -|y1 - y0|`. Each cycle, let `d = 2 * err`. If `d > sy`, x steps and `sy` is added to err. If `d < sx`, y steps and `sx` is added to err. Both tests use the same `d`. The line lasts exactly `max(|x1-x0|, |y1-y0|) + 1` valid cycles.
- R6: The last valid pixel equals (`x1`, `y1`). In the next cycle `done` is 1 and `pix_valid` is 0. The two outputs are never high together, and `done` only rises right after a valid pixel.
- R7: When both endpoints are the same, exactly one pixel is emitted before `done`.
- R8: With `done` high and no `start`, `done` stays high and `pix_valid` stays low.
- R9: A `start` pulse while `done` is high begins a new line under R2.
- R10: A `start` pulse while a line is in progress is ignored, and the pixel sequence continues unchanged.
- R11: The line from (0,0) to (7,4) yields (0,0) (1,1) (2,1) (3,2) (4,2) (5,3) (6,3) (7,4).
- R12: Spans up to the full coordinate range work without overflow. The line from (0,100) to (65535,101) emits 65536 pixels and ends at (65535,101).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a line |
| x0 | input | 16 | Start point x, sampled with `start` |
| y0 | input | 16 | Start point y, sampled with `start` |
| x1 | input | 16 | End point x, sampled with `start` |
| y1 | input | 16 | End point y, sampled with `start` |
| pix_x | output | 16 | Current pixel x |
| pix_y | output | 16 | Current pixel y |
| pix_valid | output | 1 | Pixel on `pix_x`/`pix_y` is part of the line |
| done | output | 1 | Last pixel has been emitted |

## Verification
The properties assume that `start` is a clean synchronous level that is never X after reset. They also assume the coordinate inputs are stable at the edge where `start` is sampled. The first-pixel property compares against the coordinate inputs as they were one cycle earlier. The bench therefore drives every input on the falling edge and holds the endpoints through the sampling edge. Only then does it scramble them, to exercise R2 and R10. The neighbour property assumes a new line never begins mid-stream. The bench only issues mid-line `start` pulses to test that they are ignored.

// File: rtl/line_walk_pkg.sv
package line_walk_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_RUN  = 2'd1,
        WALK_FIN  = 2'd2
    } walk_state_e;

endpackage

// File: rtl/line_setup.sv
// Combinational setup: spans, directions and initial error from endpoints.
module line_setup #(
    parameter int CW = 16,
    parameter int EW = CW + 2
) (
    input  logic [CW-1:0]        from_x,
    input  logic [CW-1:0]        from_y,
    input  logic [CW-1:0]        to_x,
    input  logic [CW-1:0]        to_y,
    output logic signed [EW-1:0] span_x,
    output logic signed [EW-1:0] span_y,
    output logic                 dir_xpos,
    output logic                 dir_ypos,
    output logic signed [EW-1:0] err_init
);
    localparam int PAD = EW - CW;

    logic signed [EW-1:0] raw_x;
    logic signed [EW-1:0] raw_y;

    always_comb begin
        raw_x = $signed({{PAD{1'b0}}, to_x}) - $signed({{PAD{1'b0}}, from_x});
        raw_y = $signed({{PAD{1'b0}}, to_y}) - $signed({{PAD{1'b0}}, from_y});

        // Strictly positive difference selects the incrementing direction.
        dir_xpos = !raw_x[EW-1] && (raw_x != '0);
        dir_ypos = !raw_y[EW-1] && (raw_y != '0);

        // Horizontal span kept non-negative, vertical span kept non-positive.
        span_x = dir_xpos ? raw_x : -raw_x;
        span_y = dir_ypos ? -raw_y : raw_y;

        err_init = span_x + span_y;
    end

endmodule

// File: rtl/line_stepper.sv
// Combinational step: one shared doubled error drives both axis decisions.
module line_stepper #(
    parameter int CW = 16,
    parameter int EW = CW + 2
) (
    input  logic signed [EW-1:0] err,
    input  logic signed [EW-1:0] span_x,
    input  logic signed [EW-1:0] span_y,
    input  logic                 dir_xpos,
    input  logic                 dir_ypos,
    input  logic [CW-1:0]        cur_x,
    input  logic [CW-1:0]        cur_y,
    output logic signed [EW-1:0] err_next,
    output logic [CW-1:0]        x_next,
    output logic [CW-1:0]        y_next
);
    localparam int DW = EW + 1;

    logic signed [DW-1:0] dbl_err;
    logic signed [DW-1:0] wide_sx;
    logic signed [DW-1:0] wide_sy;
    logic                 move_x;
    logic                 move_y;
    logic signed [EW-1:0] add_x;
    logic signed [EW-1:0] add_y;

    always_comb begin
        dbl_err = {err, 1'b0};
        wide_sx = {span_x[EW-1], span_x};
        wide_sy = {span_y[EW-1], span_y};

        move_x = dbl_err > wide_sy;
        move_y = dbl_err < wide_sx;

        add_x = move_x ? span_y : '0;
        add_y = move_y ? span_x : '0;
        err_next = err + add_x + add_y;

        x_next = cur_x;
        if (move_x) begin
            x_next = dir_xpos ? cur_x + CW'(1) : cur_x - CW'(1);
        end

        y_next = cur_y;
        if (move_y) begin
            y_next = dir_ypos ? cur_y + CW'(1) : cur_y - CW'(1);
        end
    end

endmodule

// File: rtl/line_walker.sv
module line_walker #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] x0,
    input  logic [CW-1:0] y0,
    input  logic [CW-1:0] x1,
    input  logic [CW-1:0] y1,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic          pix_valid,
    output logic          done
);
    import line_walk_pkg::*;

    localparam int EW = CW + 2;

    typedef struct packed {
        walk_state_e          st;
        logic [CW-1:0]        x;
        logic [CW-1:0]        y;
        logic [CW-1:0]        end_x;
        logic [CW-1:0]        end_y;
        logic signed [EW-1:0] err;
        logic signed [EW-1:0] sx;
        logic signed [EW-1:0] sy;
        logic                 xpos;
        logic                 ypos;
    } walk_t;

    localparam walk_t WALK_RST = '{st: WALK_IDLE, default: '0};

    walk_t walk_d;
    walk_t walk_q;

    logic signed [EW-1:0] su_sx;
    logic signed [EW-1:0] su_sy;
    logic                 su_xpos;
    logic                 su_ypos;
    logic signed [EW-1:0] su_err;

    logic signed [EW-1:0] st_err;
    logic [CW-1:0]        st_x;
    logic [CW-1:0]        st_y;
    logic                 at_end;

    line_setup #(.CW(CW), .EW(EW)) u_setup (
        .from_x   (x0),
        .from_y   (y0),
        .to_x     (x1),
        .to_y     (y1),
        .span_x   (su_sx),
        .span_y   (su_sy),
        .dir_xpos (su_xpos),
        .dir_ypos (su_ypos),
        .err_init (su_err)
    );

    line_stepper #(.CW(CW), .EW(EW)) u_step (
        .err      (walk_q.err),
        .span_x   (walk_q.sx),
        .span_y   (walk_q.sy),
        .dir_xpos (walk_q.xpos),
        .dir_ypos (walk_q.ypos),
        .cur_x    (walk_q.x),
        .cur_y    (walk_q.y),
        .err_next (st_err),
        .x_next   (st_x),
        .y_next   (st_y)
    );

    always_comb begin
        walk_d = walk_q;
        at_end = (walk_q.x == walk_q.end_x) && (walk_q.y == walk_q.end_y);

        unique case (walk_q.st)
            WALK_IDLE, WALK_FIN: begin
                if (start) begin
                    walk_d.st    = WALK_RUN;
                    walk_d.x     = x0;
                    walk_d.y     = y0;
                    walk_d.end_x = x1;
                    walk_d.end_y = y1;
                    walk_d.err   = su_err;
                    walk_d.sx    = su_sx;
                    walk_d.sy    = su_sy;
                    walk_d.xpos  = su_xpos;
                    walk_d.ypos  = su_ypos;
                end
            end
            WALK_RUN: begin
                if (at_end) begin
                    walk_d.st = WALK_FIN;
                end else begin
                    walk_d.x   = st_x;
                    walk_d.y   = st_y;
                    walk_d.err = st_err;
                end
            end
            default: walk_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= WALK_RST;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign pix_x     = walk_q.x;
    assign pix_y     = walk_q.y;
    assign pix_valid = (walk_q.st == WALK_RUN);
    assign done      = (walk_q.st == WALK_FIN);

endmodule

// File: rtl/line_walker_chk.sv
module line_walker_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [CW-1:0] x0,
    input logic [CW-1:0] y0,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] pix_y,
    input logic          pix_valid,
    input logic          done
);
    logic [CW-1:0] prev_x;
    logic [CW-1:0] prev_y;
    logic          prev_v;
    logic [CW-1:0] dlt_x;
    logic [CW-1:0] dlt_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_x <= '0;
            prev_y <= '0;
            prev_v <= 1'b0;
        end else begin
            prev_x <= pix_x;
            prev_y <= pix_y;
            prev_v <= pix_valid;
        end
    end

    assign dlt_x = pix_x - prev_x;
    assign dlt_y = pix_y - prev_y;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && !done));

    assert_first_pixel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pix_valid) |=> (pix_valid && pix_x == $past(x0) && pix_y == $past(y0)));

    assert_neighbour_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && prev_v) |->
            ((dlt_x == '0 || dlt_x == CW'(1) || dlt_x == '1) &&
             (dlt_y == '0 || dlt_y == CW'(1) || dlt_y == '1) &&
             (dlt_x != '0 || dlt_y != '0)));

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pix_valid, done}));

    assert_done_after_pixel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(pix_valid));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

bind line_walker line_walker_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .x0        (x0),
    .y0        (y0),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pix_valid (pix_valid),
    .done      (done)
);

// File: tb/line_walker_bench.sv
module line_walker_bench;

    localparam int CW    = 16;
    localparam int LIMIT = 70000;
    localparam int NVEC  = 13;

    typedef struct packed {
        logic [15:0] ax;
        logic [15:0] ay;
        logic [15:0] bx;
        logic [15:0] by;
        logic [16:0] n;
    } vec_t;

    // start x, start y, end x, end y, expected pixel count
    localparam vec_t VEC [NVEC] = '{
        '{16'd0,     16'd0,     16'd7,     16'd4,     17'd8},
        '{16'd7,     16'd4,     16'd0,     16'd0,     17'd8},
        '{16'd3,     16'd3,     16'd3,     16'd3,     17'd1},
        '{16'd5,     16'd9,     16'd20,    16'd9,     17'd16},
        '{16'd20,    16'd9,     16'd5,     16'd9,     17'd16},
        '{16'd40,    16'd2,     16'd40,    16'd30,    17'd29},
        '{16'd40,    16'd30,    16'd40,    16'd2,     17'd29},
        '{16'd0,     16'd0,     16'd3,     16'd11,    17'd12},
        '{16'd10,    16'd20,    16'd1,     16'd5,     17'd16},
        '{16'd2,     16'd12,    16'd14,    16'd0,     17'd13},
        '{16'd100,   16'd50,    16'd90,    16'd57,    17'd11},
        '{16'd10,    16'd65535, 16'd0,     16'd65530, 17'd11},
        '{16'd0,     16'd100,   16'd65535, 16'd101,   17'd65536}
    };

    logic          clk;
    logic          rst_n;
    logic          start;
    logic [CW-1:0] x0, y0, x1, y1;
    logic [CW-1:0] pix_x, pix_y;
    logic          pix_valid;
    logic          done;

    int checks = 0;
    int errors = 0;
    int px [16];
    int py [16];

    line_walker #(.CW(CW)) u_line_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .x0        (x0),
        .y0        (y0),
        .x1        (x1),
        .y1        (y1),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_valid (pix_valid),
        .done      (done)
    );

    initial clk = 1'b0;
    always #4ns clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic run_line(input logic [15:0] ax, input logic [15:0] ay,
                            input logic [15:0] bx, input logic [15:0] by,
                            input int n, input bit poke);
        int  mdx, mdy, merr, me2, mx, my, got, lx, ly, sgx, sgy;
        bit  mr, md, fx, fy;
        @(negedge clk);
        x0 = ax; y0 = ay; x1 = bx; y1 = by; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        x0 = ~ax; y0 = ~ay; x1 = ~bx; y1 = ~by;   // R2: later input changes ignored
        mdx = int'(bx) - int'(ay - ay) - int'(ax);
        mr  = mdx > 0;
        if (!mr) mdx = -mdx;
        mdy = int'(by) - int'(ay);
        md  = mdy > 0;
        if (md) mdy = -mdy;
        merr = mdx + mdy;
        mx = int'(ax); my = int'(ay);
        sgx = mr ? 1 : -1;
        sgy = md ? 1 : -1;
        got = 0; lx = -1; ly = -1;
        while (pix_valid && got < LIMIT) begin
            chk(int'(pix_x) == mx, "R5", "pixel x", int'(pix_x), mx);
            chk(int'(pix_y) == my, "R5", "pixel y", int'(pix_y), my);
            if (got == 0) begin
                chk(int'(pix_x) == int'(ax) && int'(pix_y) == int'(ay), "R2",
                    "first pixel", int'(pix_x), int'(ax));
            end else begin
                chk((int'(pix_x) - lx) inside {-1, 0, 1} &&
                    (int'(pix_y) - ly) inside {-1, 0, 1} &&
                    !(int'(pix_x) == lx && int'(pix_y) == ly), "R3",
                    "neighbour step x", int'(pix_x), lx);
                chk(int'(pix_x) == lx || int'(pix_x) - lx == sgx, "R4",
                    "x direction", int'(pix_x) - lx, sgx);
                chk(int'(pix_y) == ly || int'(pix_y) - ly == sgy, "R4",
                    "y direction", int'(pix_y) - ly, sgy);
            end
            if (got < 16) begin
                px[got] = int'(pix_x);
                py[got] = int'(pix_y);
            end
            lx = int'(pix_x); ly = int'(pix_y);
            got++;
            if (!(mx == int'(bx) && my == int'(by))) begin
                me2 = 2 * merr;
                fx = me2 > mdy;
                fy = me2 < mdx;
                if (fx) begin merr += mdy; mx += sgx; end
                if (fy) begin merr += mdx; my += sgy; end
            end
            if (poke && got == 2) begin
                start = 1'b1;                        // R10: ignored mid-line
                x0 = 16'd999; y0 = 16'd999; x1 = 16'd5; y1 = 16'd5;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(got == n, (n == 1) ? "R7" : "R5", "pixel count", got, n);
        chk(lx == int'(bx) && ly == int'(by), "R6", "last pixel x", lx, int'(bx));
        chk(done == 1'b1 && pix_valid == 1'b0, "R6", "done after last", int'(done), 1);
    endtask

    initial begin
        int wx [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
        int wy [8] = '{0, 1, 1, 2, 2, 3, 3, 4};
        rst_n = 1'b0; start = 1'b0;
        x0 = '0; y0 = '0; x1 = '0; y1 = '0;
        @(negedge clk);
        chk(!pix_valid && !done, "R1", "quiet in reset", int'(pix_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pix_valid && !done, "R1", "quiet after reset", int'(done), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_line(VEC[i].ax, VEC[i].ay, VEC[i].bx, VEC[i].by, int'(VEC[i].n), 1'b0);
            if (i == 0) begin
                for (int k = 0; k < 8; k++) begin
                    chk(px[k] == wx[k] && py[k] == wy[k], "R11", "known line pixel",
                        px[k] * 100 + py[k], wx[k] * 100 + wy[k]);
                end
            end
        end
        chk(1'b1, "R12", "full-span line completed above", 0, 0);

        // R8: finished state holds without start
        repeat (5) begin
            @(negedge clk);
            chk(done && !pix_valid, "R8", "done holds", int'(done), 1);
        end

        // R10: mid-line start pulse is ignored; R9: restart from finished
        run_line(16'd3, 16'd40, 16'd30, 16'd22, 28, 1'b1);
        run_line(16'd60, 16'd0, 16'd50, 16'd9, 11, 1'b0);
        chk(done, "R9", "restart from done completed", int'(done), 1);

        for (int r = 0; r < 40; r++) begin
            logic [15:0] ax, ay, bx, by;
            int ex, ey;
            ax = 16'($urandom_range(0, 200));
            ay = 16'($urandom_range(0, 200));
            bx = 16'($urandom_range(0, 200));
            by = 16'($urandom_range(0, 200));
            ex = int'(bx) - int'(ax); if (ex < 0) ex = -ex;
            ey = int'(by) - int'(ay); if (ey < 0) ey = -ey;
            run_line(ax, ay, bx, by, ((ex > ey) ? ex : ey) + 1, r[0]);
        end

        summary();
        $finish;
    end

    initial begin
        #(8ns * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule